// File: doc/BRIEF.md
# Prioritized interrupt controller

This block collects interrupt requests from eight external request lines, a set of internal peripheral lines and one non-maskable line, and presents the CPU with the single most urgent one. Every source has a 4-bit priority held in a nibble of a 16-bit priority register. Several peripheral lines may share one nibble. The block compares the winning priority against the CPU's current mask level and outputs a request flag, the priority level and the vector number.

The external lines are active low. Each can be sensed by level, in which case the request follows the pin, or by falling edge. An edge is latched and stays pending until the CPU acknowledges its vector. The non-maskable line is always edge sensed, and a control bit selects the active edge. It beats every other source and ignores the mask. Configuration is written through a small register write port. The control register can be read back together with the live level of the non-maskable pin.

Top module: `prio_intc`

## Requirements
- R1: After reset all priority registers and the control register are zero, so every line is level sensed, the non-maskable edge is falling, and no request is output.
- R2: Priority register 0 holds the levels of external lines 0, 1, 2 and 3 in bits 15:12, 11:8, 7:4 and 3:0. Register 1 holds lines 4 to 7 in the same way.
- R3: Register 2 holds the peripheral fields, field f in bits 15-4f down to 12-4f. Peripheral lines 2f and 2f+1 share field f.
- R4: A source whose priority is 0 never produces a request.
- R5: A source produces a request only when its priority is strictly greater than `cpu_mask`.
- R6: The highest eligible priority wins. On a tie the source with the lower index wins. External line k has index k and peripheral line j has index 8+j.
- R7: The vector output for source index i is 64+i, and `irq_lvl` shows that source's priority.
- R8: Control bit k (k = 0..7) set selects falling-edge sensing for external line k. Clear selects level sensing, where a request is present exactly while the pin is low.
- R9: An edge-latched request stays pending until an acknowledge carrying its own vector. An acknowledge with any other vector leaves it pending, and a pin held low after the acknowledge does not raise it again.
- R10: Control bit 8 set makes a rising edge on `nmi_pin` the trigger, and clear makes a falling edge the trigger. A latched non-maskable event outputs vector 11 at level 15. It wins over every other source, regardless of `cpu_mask`, and stays until acknowledged with vector 11.
- R11: `ctl_rdata` returns control bits 8:0 as written, bits 14:9 as zero and bit 15 as the present level of `nmi_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0..2 priority registers, 3 control |
| cfg_wdata | input | 16 | Write data |
| ctl_rdata | output | 16 | Control register read-back with NMI pin level in bit 15 |
| ext_irq_n | input | 8 | External request lines, active low |
| periph_req | input | 8 | Peripheral level requests, active high |
| nmi_pin | input | 1 | Non-maskable request line |
| cpu_mask | input | 4 | CPU's current interrupt mask level |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vec | input | 8 | Vector being acknowledged |
| irq_req | output | 1 | A request is presented to the CPU |
| irq_lvl | output | 4 | Priority level of the presented request |
| irq_vec | output | 8 | Vector number of the presented request |

## Verification
The bench drives single requests on each register nibble with distinct priority values, so a wrong nibble position shows up as the wrong level or vector. Paired requests with equal and unequal priorities separate the tie rule from the magnitude comparison. Masks equal to and one below a priority probe the strict comparison. Short low pulses in edge mode, together with acknowledges using a wrong and then the right vector, tell latching apart from level following. Non-maskable edges of both polarities are applied under a full mask and a competing request.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_PFIELD = 4,
  parameter int SHARE    = 2,
  parameter int VEC_BASE = 64,
  parameter int VEC_NMI  = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] ctl_rdata,
  input  logic [7:0]  ext_irq_n,
  input  logic [7:0]  periph_req,
  input  logic        nmi_pin,
  input  logic [3:0]  cpu_mask,
  input  logic        ack_valid,
  input  logic [7:0]  ack_vec,
  output logic        irq_req,
  output logic [3:0]  irq_lvl,
  output logic [7:0]  irq_vec
);
  localparam int N_EXT = 8;
  localparam int N_PER = N_PFIELD * SHARE;
  localparam int N_SRC = N_EXT + N_PER;
  localparam int NPREG = 2 + (N_PFIELD + 3) / 4;
  localparam int IDXW  = $clog2(N_SRC);
  localparam logic [1:0] CTL_SEL = 2'(NPREG);

  logic [15:0]      preg [NPREG];
  logic [7:0]       ctl_sense;
  logic             ctl_nmi_rise;
  logic [7:0]       ext_prev, edge_pend;
  logic             nmi_prev, nmi_pend;
  logic [3:0]       pri [N_SRC];
  logic [N_SRC-1:0] src_req;
  logic [7:0]       ext_req;
  logic [3:0]       best_lvl;
  logic [IDXW-1:0]  best_idx;
  logic             nmi_edge;

  always_ff @(posedge clk) begin
    for (int r = 0; r < NPREG; r++) begin
      if (!rst_n) preg[r] <= '0;
      else if (cfg_we && cfg_sel == 2'(r)) preg[r] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_sense    <= '0;
      ctl_nmi_rise <= 1'b0;
    end else if (cfg_we && cfg_sel == CTL_SEL) begin
      ctl_sense    <= cfg_wdata[7:0];
      ctl_nmi_rise <= cfg_wdata[8];
    end
  end

  assign ctl_rdata = {nmi_pin, 6'b0, ctl_nmi_rise, ctl_sense};

  assign nmi_edge = ctl_nmi_rise ? (!nmi_prev && nmi_pin) : (nmi_prev && !nmi_pin);

  always_ff @(posedge clk) begin
    ext_prev <= ext_irq_n;
    nmi_prev <= nmi_pin;
    if (!rst_n) begin
      edge_pend <= '0;
      nmi_pend  <= 1'b0;
    end else begin
      for (int k = 0; k < N_EXT; k++) begin
        if (ctl_sense[k] && ext_prev[k] && !ext_irq_n[k])
          edge_pend[k] <= 1'b1;
        else if (!ctl_sense[k] || (ack_valid && ack_vec == 8'(VEC_BASE + k)))
          edge_pend[k] <= 1'b0;
      end
      if (nmi_edge) nmi_pend <= 1'b1;
      else if (ack_valid && ack_vec == 8'(VEC_NMI)) nmi_pend <= 1'b0;
    end
  end

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign pri[g]     = preg[g / 4][15 - 4 * (g % 4) -: 4];
    assign ext_req[g] = ctl_sense[g] ? edge_pend[g] : !ext_irq_n[g];
  end

  for (genvar p = 0; p < N_PER; p++) begin : g_per
    localparam int F = p / SHARE;
    assign pri[N_EXT + p] = preg[2 + F / 4][15 - 4 * (F % 4) -: 4];
  end

  assign src_req = {periph_req[N_PER-1:0], ext_req};

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (src_req[i] && pri[i] > cpu_mask && pri[i] > best_lvl) begin
        best_lvl = pri[i];
        best_idx = IDXW'(i);
      end
    end
  end

  assign irq_req = nmi_pend || (best_lvl != 4'd0);
  assign irq_lvl = nmi_pend ? 4'hF : best_lvl;
  assign irq_vec = nmi_pend ? 8'(VEC_NMI) : 8'(VEC_BASE) + 8'(best_idx);

  // R5
  mask_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !nmi_pend) |-> (irq_lvl > cpu_mask));

  // R4
  nonzero_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec != 8'(VEC_NMI)) |-> (irq_lvl != 4'd0));

  // R7
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !nmi_pend) |-> (int'(irq_vec) >= VEC_BASE && int'(irq_vec) < VEC_BASE + N_SRC));

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> ((($past(edge_pend) & $past(ctl_sense)) & ~edge_pend) == '0));

  // R10
  nmi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_pend) |-> ($past(nmi_pin, 2) != $past(nmi_pin)));
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] ctl_rdata;
  logic [7:0]  ext_irq_n = 8'hFF;
  logic [7:0]  periph_req = 0;
  logic        nmi_pin = 1;
  logic [3:0]  cpu_mask = 0;
  logic        ack_valid = 0;
  logic [7:0]  ack_vec = 0;
  logic        irq_req;
  logic [3:0]  irq_lvl;
  logic [7:0]  irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  prio_intc u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctl_rdata(ctl_rdata), .ext_irq_n(ext_irq_n),
    .periph_req(periph_req), .nmi_pin(nmi_pin), .cpu_mask(cpu_mask),
    .ack_valid(ack_valid), .ack_vec(ack_vec), .irq_req(irq_req),
    .irq_lvl(irq_lvl), .irq_vec(irq_vec)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_irq(string tag, bit req, int lvl, int vec);
    chk({tag, " req"}, int'(irq_req), int'(req));
    if (req) begin
      chk({tag, " lvl"}, int'(irq_lvl), lvl);
      chk({tag, " vec"}, int'(irq_vec), vec);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ack(logic [7:0] v);
    ack_valid = 1; ack_vec = v;
    @(negedge clk);
    ack_valid = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    expect_irq("R1 after reset", 0, 0, 0);
    chk("R1 R11 ctl readback", int'(ctl_rdata), 16'h8000);
    ext_irq_n = 8'h00; settle();
    expect_irq("R1 zero priorities", 0, 0, 0);
    ext_irq_n = 8'hFF; settle();
  endtask

  task automatic t_map();
    wr(0, 16'h1234); wr(1, 16'h5678);
    ext_irq_n = 8'hFB; settle();
    expect_irq("R2 line2", 1, 3, 66);
    ext_irq_n = 8'hF7; settle();
    expect_irq("R2 line3", 1, 4, 67);
    ext_irq_n = 8'hFE; settle();
    expect_irq("R2 R7 line0", 1, 1, 64);
    ext_irq_n = 8'hDF; settle();
    expect_irq("R2 line5", 1, 6, 69);
    ext_irq_n = 8'hFF; settle();
  endtask

  task automatic t_periph();
    wr(2, 16'h9A00);
    periph_req = 8'h02; settle();
    expect_irq("R3 periph1 field0", 1, 9, 73);
    periph_req = 8'h08; settle();
    expect_irq("R3 periph3 field1", 1, 10, 75);
    periph_req = 8'h0A; settle();
    expect_irq("R6 periph higher wins", 1, 10, 75);
    periph_req = 8'h10; settle();
    expect_irq("R4 periph zero field", 0, 0, 0);
    periph_req = 8'h00; settle();
  endtask

  task automatic t_zero_mask();
    wr(0, 16'h0234);
    ext_irq_n = 8'hFE; settle();
    expect_irq("R4 zero priority line0", 0, 0, 0);
    ext_irq_n = 8'hFD; cpu_mask = 2; settle();
    expect_irq("R5 mask equal", 0, 0, 0);
    cpu_mask = 1; settle();
    expect_irq("R5 mask below", 1, 2, 65);
    cpu_mask = 0; ext_irq_n = 8'hFF; settle();
  endtask

  task automatic t_tie();
    wr(0, 16'h3333);
    ext_irq_n = 8'hF5; settle();
    expect_irq("R6 tie lower index", 1, 3, 65);
    wr(0, 16'h3335);
    settle();
    expect_irq("R6 higher priority", 1, 5, 67);
    wr(2, 16'h5000);
    periph_req = 8'h01; ext_irq_n = 8'hF7; settle();
    expect_irq("R6 tie ext over periph", 1, 5, 67);
    periph_req = 8'h00; ext_irq_n = 8'hFF; settle();
  endtask

  task automatic t_level();
    wr(0, 16'h0060);
    ext_irq_n = 8'hFB; settle();
    expect_irq("R8 level low", 1, 6, 66);
    ext_irq_n = 8'hFF; settle();
    expect_irq("R8 level released", 0, 0, 0);
  endtask

  task automatic t_edge();
    wr(1, 16'h7000);
    wr(3, 16'h0010);
    expect_irq("R8 edge mode idle", 0, 0, 0);
    ext_irq_n = 8'hEF; settle();
    ext_irq_n = 8'hFF; settle();
    expect_irq("R8 edge latched", 1, 7, 68);
    ack(8'd69);
    expect_irq("R9 wrong ack kept", 1, 7, 68);
    ack(8'd68);
    expect_irq("R9 ack clears", 0, 0, 0);
    ext_irq_n = 8'hEF; settle();
    expect_irq("R8 edge while low", 1, 7, 68);
    ack(8'd68);
    settle();
    expect_irq("R9 held low no retrigger", 0, 0, 0);
    ext_irq_n = 8'hFF; settle();
    expect_irq("R8 rising ignored", 0, 0, 0);
  endtask

  task automatic t_nmi();
    wr(0, 16'h0F00);
    ext_irq_n = 8'hFD; cpu_mask = 4'hF; settle();
    expect_irq("R5 full mask", 0, 0, 0);
    nmi_pin = 0; settle();
    expect_irq("R10 falling nmi", 1, 15, 11);
    chk("R11 pin low readback", int'(ctl_rdata), 16'h0010);
    cpu_mask = 0; settle();
    expect_irq("R10 nmi beats level15", 1, 15, 11);
    ack(8'd65);
    expect_irq("R10 nmi kept", 1, 15, 11);
    ack(8'd11);
    expect_irq("R10 nmi cleared", 1, 15, 65);
    ext_irq_n = 8'hFF;
    wr(3, 16'h0100);
    chk("R11 rise bit readback", int'(ctl_rdata), 16'h0100);
    expect_irq("R10 no spurious", 0, 0, 0);
    nmi_pin = 1; settle();
    expect_irq("R10 rising nmi", 1, 15, 11);
    ack(8'd11);
    nmi_pin = 0; settle();
    expect_irq("R10 falling ignored", 0, 0, 0);
    nmi_pin = 1; settle();
    ack(8'd11);
    wr(3, 16'hFFFF);
    chk("R11 full readback", int'(ctl_rdata), 16'h81FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    t_reset();
    t_map();
    t_periph();
    t_zero_mask();
    t_tie();
    t_level();
    t_edge();
    t_nmi();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule